// File: doc/BRIEF.md
# LIN Frame Identifier and Response Controller

This block runs the frame-level part of a LIN node, sitting above a byte-level serial transmitter and receiver (both outside this block, as are break and sync). A frame starts on one of two header-start pulses. On a transmit header it emits the identifier byte through the transmit handshake. On a receive header it takes the first received byte as the identifier. Either way it can insert, or check, the two identifier parity bits, or pass all eight bits through unchanged.

Once the identifier is known, the block works out how many data bytes the response has. The count comes either from a user length register or from two identifier bits. The block then carries out the node action sampled for that frame. It can publish the data bytes and the checksum, subscribe to them and verify the checksum, or ignore them while still counting them. A one-clock completion pulse marks the end of every response.

Top module: `lin_frame_ctrl`

## Requirements
- R1: After reset, tx_valid, sub_valid, resp_done, err_id_parity and err_checksum are low, and id_out is zero.
- R2: With cfg_par_off low, the transmitted header byte is {P1, P0, cfg_id[5:0]}, where bit 6 is P0 = id0^id1^id2^id4 and bit 7 is P1 = ~(id1^id3^id4^id5).
- R3: With cfg_par_off high, the transmitted header byte equals cfg_id unchanged.
- R4: With cfg_par_off low, a received identifier is stored on id_out with bits 7:6 forced to zero. err_id_parity is set if the received bits 7:6 differ from the parity computed over bits 5:0. Both error flags are cleared by either header-start pulse.
- R5: With cfg_par_off high, all eight received identifier bits are stored on id_out and no parity error is raised.
- R6: With cfg_len_from_id low, the response has cfg_dlc+1 data bytes (1 to 256).
- R7: With cfg_len_from_id high, identifier bits 5:4 select the data byte count: 00 and 01 give 2, 10 gives 4, 11 gives 8.
- R8: With cfg_action = 00 (publish), the block sends the data bytes taken from pub_data, pulsing pub_pop for each accepted byte, and then sends one checksum byte. tx_ready stalls are honoured.
- R9: The checksum is the bitwise inverse of the 8-bit sum of the data bytes, where every carry out of bit 7 is added back in.
- R10: With cfg_action = 01 (subscribe), each received data byte appears on sub_data with sub_valid high for its cycle. The following byte is compared with the checksum, and a mismatch sets err_checksum.
- R11: With cfg_action = 10 or 11 (ignore), the response bytes are counted but are neither forwarded nor transmitted, and they raise no error.
- R12: resp_done is high for exactly one clock, in the cycle after the checksum byte (or the final ignored byte) is handled. The block is then idle, so further bytes are neither forwarded nor transmitted.
- R13: A header-start pulse during a response abandons that response without a resp_done, and the new frame runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_id | input | 8 | Identifier value for transmitted headers |
| cfg_par_off | input | 1 | High: no parity insertion or checking |
| cfg_len_from_id | input | 1 | High: length from identifier bits 5:4 |
| cfg_dlc | input | DLC_W | User length minus one |
| cfg_action | input | 2 | 00 publish, 01 subscribe, 1x ignore; sampled at header end |
| hdr_tx_start | input | 1 | Pulse: send a header identifier |
| hdr_rx_start | input | 1 | Pulse: next received byte is an identifier |
| pub_data | input | 8 | Next data byte to publish |
| pub_pop | output | 1 | pub_data consumed this cycle |
| tx_byte | output | 8 | Byte to the serial transmitter |
| tx_valid | output | 1 | tx_byte is valid |
| tx_ready | input | 1 | Transmitter accepts tx_byte |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | rx_byte valid for one cycle |
| sub_data | output | 8 | Received response data byte |
| sub_valid | output | 1 | sub_data is a data byte of a subscribed response |
| id_out | output | 8 | Last received identifier as stored |
| resp_done | output | 1 | One-clock response completion pulse |
| err_id_parity | output | 1 | Identifier parity mismatch flag |
| err_checksum | output | 1 | Response checksum mismatch flag |

## Verification
A wrong byte counter or a wrong length decode shows up at the ports straight away. The checksum byte is transmitted one handshake early or late, so the byte-by-byte comparison of the transmit stream fails on the first misplaced byte. On receive, resp_done moves away from the cycle after the last byte. A corrupted checksum accumulator appears only on the final transmitted byte, or as a wrong err_checksum one cycle after the checksum arrives. For this reason the data patterns are chosen so that the sum carries out many times. A stale node action or a stale parity mode shows at once as sub_valid or tx_valid in the wrong frame, or as a wrong id_out one cycle after the identifier byte.

// File: rtl/lin_fc_pkg.sv
package lin_fc_pkg;

   typedef enum logic [1:0] {
      ACT_PUB  = 2'd0,
      ACT_SUB  = 2'd1,
      ACT_IGN  = 2'd2,
      ACT_IGNX = 2'd3
   } act_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HTX  = 3'd1,
      ST_HRX  = 3'd2,
      ST_DATA = 3'd3,
      ST_CK   = 3'd4
   } st_e;

   // {bit7, bit6} parity over identifier bits 5:0
   function automatic logic [1:0] id_parity(input logic [5:0] id);
      return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4]};
   endfunction

endpackage

// File: rtl/lin_id_unit.sv
module lin_id_unit
   import lin_fc_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic [ID_W-1:0] tx_id,
   input  logic [ID_W-1:0] rx_id,
   input  logic            par_off,
   output logic [ID_W-1:0] hdr_byte,
   output logic [ID_W-1:0] rx_store,
   output logic            rx_par_bad
);
   localparam int PAY_W = ID_W - 2;

   generate
      if (ID_W != 8) begin : g_bad_width
         $error("lin_id_unit: identifier must be 8 bits");
      end
   endgenerate

   logic [1:0] tx_par;
   logic [1:0] rx_par;

   always_comb begin
      tx_par = id_parity(tx_id[PAY_W-1:0]);
      rx_par = id_parity(rx_id[PAY_W-1:0]);
      if (par_off) begin
         hdr_byte   = tx_id;
         rx_store   = rx_id;
         rx_par_bad = 1'b0;
      end else begin
         hdr_byte   = {tx_par, tx_id[PAY_W-1:0]};
         rx_store   = {2'b00, rx_id[PAY_W-1:0]};
         rx_par_bad = (rx_id[ID_W-1:PAY_W] != rx_par);
      end
   end
endmodule

// File: rtl/lin_len_decode.sv
module lin_len_decode #(
   parameter int DLC_W = 8,
   parameter int CNT_W = DLC_W + 1
) (
   input  logic [1:0]       id_len_bits,
   input  logic             len_from_id,
   input  logic [DLC_W-1:0] dlc,
   output logic [CNT_W-1:0] len
);
   generate
      if (DLC_W < 3) begin : g_bad_dlc
         $error("lin_len_decode: DLC_W must reach 8 bytes");
      end
      if (CNT_W != DLC_W + 1) begin : g_bad_cnt
         $error("lin_len_decode: CNT_W must be DLC_W+1");
      end
   endgenerate

   logic [CNT_W-1:0] user_len;
   logic [CNT_W-1:0] id_len;

   always_comb begin
      user_len = {1'b0, dlc} + CNT_W'(1);
      unique case (id_len_bits)
         2'b11:   id_len = CNT_W'(8);
         2'b10:   id_len = CNT_W'(4);
         default: id_len = CNT_W'(2);
      endcase
      len = len_from_id ? id_len : user_len;
   end
endmodule

// File: rtl/lin_csum_acc.sv
module lin_csum_acc #(
   parameter int B_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           add_en,
   input  logic [B_W-1:0] byte_in,
   output logic [B_W-1:0] csum
);
   logic [B_W-1:0] acc_q;
   logic [B_W:0]   wide;
   logic [B_W-1:0] folded;

   always_comb begin
      wide   = {1'b0, acc_q} + {1'b0, byte_in};
      folded = wide[B_W-1:0] + B_W'(wide[B_W]);
      csum   = ~acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (add_en) acc_q <= folded;
   end
endmodule

// File: rtl/lin_frame_ctrl.sv
module lin_frame_ctrl
   import lin_fc_pkg::*;
#(
   parameter int DLC_W = 8,
   localparam int CNT_W = DLC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       cfg_id,
   input  logic             cfg_par_off,
   input  logic             cfg_len_from_id,
   input  logic [DLC_W-1:0] cfg_dlc,
   input  logic [1:0]       cfg_action,
   input  logic             hdr_tx_start,
   input  logic             hdr_rx_start,
   input  logic [7:0]       pub_data,
   output logic             pub_pop,
   output logic [7:0]       tx_byte,
   output logic             tx_valid,
   input  logic             tx_ready,
   input  logic [7:0]       rx_byte,
   input  logic             rx_valid,
   output logic [7:0]       sub_data,
   output logic             sub_valid,
   output logic [7:0]       id_out,
   output logic             resp_done,
   output logic             err_id_parity,
   output logic             err_checksum
);
   st_e              st_q;
   act_e             act_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       id_q;
   logic             done_q, epar_q, eck_q;

   logic [7:0]       hdr_byte, rx_store, csum, data_byte;
   logic             rx_par_bad;
   logic [CNT_W-1:0] len;
   logic [1:0]       len_bits;
   logic             hdr_start, is_pub, byte_evt, hdr_end, add_en;

   lin_id_unit #(.ID_W(8)) u_id (
      .tx_id      (cfg_id),
      .rx_id      (rx_byte),
      .par_off    (cfg_par_off),
      .hdr_byte   (hdr_byte),
      .rx_store   (rx_store),
      .rx_par_bad (rx_par_bad)
   );

   lin_len_decode #(.DLC_W(DLC_W), .CNT_W(CNT_W)) u_len (
      .id_len_bits (len_bits),
      .len_from_id (cfg_len_from_id),
      .dlc         (cfg_dlc),
      .len         (len)
   );

   lin_csum_acc #(.B_W(8)) u_ck (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (hdr_end),
      .add_en  (add_en),
      .byte_in (data_byte),
      .csum    (csum)
   );

   always_comb begin
      hdr_start = hdr_tx_start | hdr_rx_start;
      is_pub    = (act_q == ACT_PUB);
      len_bits  = (st_q == ST_HTX) ? cfg_id[5:4] : rx_byte[5:4];
      tx_valid  = (st_q == ST_HTX) ||
                  (is_pub && ((st_q == ST_DATA) || (st_q == ST_CK)));
      unique case (st_q)
         ST_HTX:  tx_byte = hdr_byte;
         ST_DATA: tx_byte = pub_data;
         default: tx_byte = csum;
      endcase
      byte_evt  = is_pub ? (tx_valid && tx_ready) : rx_valid;
      hdr_end   = ((st_q == ST_HTX) && tx_ready) || ((st_q == ST_HRX) && rx_valid);
      add_en    = (st_q == ST_DATA) && byte_evt && !hdr_start;
      data_byte = is_pub ? pub_data : rx_byte;
      pub_pop   = (st_q == ST_DATA) && is_pub && tx_ready;
      sub_valid = (st_q == ST_DATA) && (act_q == ACT_SUB) && rx_valid;
      sub_data  = rx_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         act_q  <= ACT_IGN;
         cnt_q  <= '0;
         id_q   <= '0;
         done_q <= 1'b0;
         epar_q <= 1'b0;
         eck_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (hdr_start) begin
            st_q   <= hdr_tx_start ? ST_HTX : ST_HRX;
            epar_q <= 1'b0;
            eck_q  <= 1'b0;
         end else begin
            unique case (st_q)
               ST_HTX: if (tx_ready) begin
                  act_q <= act_e'(cfg_action);
                  cnt_q <= len;
                  st_q  <= ST_DATA;
               end
               ST_HRX: if (rx_valid) begin
                  id_q   <= rx_store;
                  epar_q <= rx_par_bad;
                  act_q  <= act_e'(cfg_action);
                  cnt_q  <= len;
                  st_q   <= ST_DATA;
               end
               ST_DATA: if (byte_evt) begin
                  cnt_q <= cnt_q - CNT_W'(1);
                  if (cnt_q == CNT_W'(1)) st_q <= ST_CK;
               end
               ST_CK: if (byte_evt) begin
                  if ((act_q == ACT_SUB) && (rx_byte != csum)) eck_q <= 1'b1;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assign id_out        = id_q;
   assign resp_done     = done_q;
   assign err_id_parity = epar_q;
   assign err_checksum  = eck_q;
endmodule

// File: rtl/lin_frame_ctrl_chk.sv
module lin_frame_ctrl_chk
   import lin_fc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input st_e        st,
   input act_e       act,
   input logic       hdr_tx_start,
   input logic       hdr_rx_start,
   input logic       cfg_par_off,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       pub_pop,
   input logic       rx_valid,
   input logic       sub_valid,
   input logic       resp_done,
   input logic [7:0] id_out
);
   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |=> !resp_done);

   a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_done && !hdr_tx_start && !hdr_rx_start) |-> (!tx_valid && !sub_valid));

   a_r8_pop_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      pub_pop |-> (tx_valid && tx_ready));

   a_r10_sub_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid |-> rx_valid);

   a_r11_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (act[1] && (st == ST_DATA || st == ST_CK)) |-> (!sub_valid && !tx_valid));

   a_r4_top_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_HRX) && rx_valid && !cfg_par_off && !hdr_tx_start && !hdr_rx_start)
      |=> (id_out[7:6] == 2'b00));
endmodule

bind lin_frame_ctrl lin_frame_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st           (st_q),
   .act          (act_q),
   .hdr_tx_start (hdr_tx_start),
   .hdr_rx_start (hdr_rx_start),
   .cfg_par_off  (cfg_par_off),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .pub_pop      (pub_pop),
   .rx_valid     (rx_valid),
   .sub_valid    (sub_valid),
   .resp_done    (resp_done),
   .id_out       (id_out)
);

// File: tb/test_lin_frame_ctrl.sv
`timescale 1ns/1ps
module test_lin_frame_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_id = '0;
   logic       cfg_par_off = 1'b0;
   logic       cfg_len_from_id = 1'b0;
   logic [7:0] cfg_dlc = '0;
   logic [1:0] cfg_action = '0;
   logic       hdr_tx_start = 1'b0;
   logic       hdr_rx_start = 1'b0;
   logic [7:0] pub_data;
   logic       pub_pop;
   logic [7:0] tx_byte;
   logic       tx_valid;
   logic       tx_ready = 1'b1;
   logic [7:0] rx_byte = '0;
   logic       rx_valid = 1'b0;
   logic [7:0] sub_data;
   logic       sub_valid;
   logic [7:0] id_out;
   logic       resp_done;
   logic       err_id_parity;
   logic       err_checksum;

   int n_tests = 0;
   int n_fail  = 0;
   int done_cnt = 0;
   int pidx = 0;
   int cyc = 0;
   bit stall = 1'b0;
   bit pop_pend = 1'b0;
   bit finished = 1'b0;
   logic [7:0] pub_mem [0:255];
   logic [7:0] exp_q [$];

   always #2 clk = ~clk;

   assign pub_data = pub_mem[pidx[7:0]];

   lin_frame_ctrl i_lin_frame_ctrl (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] ref_par(input logic [7:0] id);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0};
   endfunction

   function automatic int ref_len(input logic [7:0] id, input bit lmode, input logic [7:0] dlc);
      if (!lmode) return int'(dlc) + 1;
      if (id[5:4] == 2'b11) return 8;
      if (id[5:4] == 2'b10) return 4;
      return 2;
   endfunction

   function automatic logic [7:0] rx_pat(input int i);
      return pub_mem[i] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] ref_ck(input int n, input bit rxside);
      int s = 0;
      for (int i = 0; i < n; i++) begin
         s += rxside ? int'(rx_pat(i)) : int'(pub_mem[i]);
         if (s > 255) s -= 255;
      end
      return ~s[7:0];
   endfunction

   // byte-stream reference comparison on every clock
   always @(negedge clk) begin
      cyc++;
      if (pop_pend) pidx++;
      tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #0.5;
      pop_pend = 1'b0;
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R11 unexpected transmit", tx_byte, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(tx_byte == e, "R2/R3/R8/R9 tx byte", tx_byte, e);
            end
            pop_pend = pub_pop;
         end
         if (resp_done) done_cnt++;
      end
   end

   task automatic do_pub(input logic [7:0] id, input bit poff, input bit lmode,
                         input logic [7:0] dlc, input bit stl);
      int n, d0;
      n = ref_len(id, lmode, dlc);
      exp_q.delete();
      exp_q.push_back(poff ? id : {ref_par(id), id[5:0]});
      for (int i = 0; i < n; i++) exp_q.push_back(pub_mem[i]);
      exp_q.push_back(ref_ck(n, 1'b0));
      @(negedge clk);
      pidx = 0; stall = stl; d0 = done_cnt;
      cfg_id = id; cfg_par_off = poff; cfg_len_from_id = lmode; cfg_dlc = dlc;
      cfg_action = 2'b00; hdr_tx_start = 1'b1;
      @(negedge clk); hdr_tx_start = 1'b0;
      for (int k = 0; k < 3000 && done_cnt == d0; k++) begin
         @(negedge clk); #1;
      end
      stall = 1'b0;
      chk(done_cnt == d0 + 1, "R12 publish done pulse", done_cnt - d0, 1);
      chk(exp_q.size() == 0, "R6/R7/R8 publish length", exp_q.size(), 0);
      chk(pidx == n, "R8 pub_pop count", pidx, n);
      @(negedge clk); #1;
      chk(!tx_valid && !resp_done, "R12 idle after publish", {tx_valid, resp_done}, 0);
   endtask

   task automatic do_rx(input logic [7:0] id, input bit poff, input bit lmode,
                        input logic [7:0] dlc, input logic [1:0] act, input bit bad_ck);
      int n;
      logic [7:0] ck;
      bit sub;
      sub = (act == 2'b01);
      n = ref_len(id, lmode, dlc);
      ck = ref_ck(n, 1'b1);
      @(negedge clk);
      cfg_par_off = poff; cfg_len_from_id = lmode; cfg_dlc = dlc; cfg_action = act;
      hdr_rx_start = 1'b1;
      @(negedge clk); hdr_rx_start = 1'b0; #1;
      chk(!err_id_parity && !err_checksum, "R4 flags cleared by header start",
          {err_id_parity, err_checksum}, 0);
      rx_byte = id; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0; #1;
      if (poff) begin
         chk(id_out == id, "R5 id stored whole", id_out, id);
         chk(!err_id_parity, "R5 no parity error", err_id_parity, 0);
      end else begin
         chk(id_out == {2'b00, id[5:0]}, "R4 id stored masked", id_out, {2'b00, id[5:0]});
         chk(err_id_parity == (id[7:6] != ref_par(id)), "R4 parity flag",
             err_id_parity, (id[7:6] != ref_par(id)));
      end
      for (int i = 0; i < n; i++) begin
         if (i % 3 == 2) begin
            @(negedge clk); rx_valid = 1'b0;
         end
         @(negedge clk);
         rx_byte = rx_pat(i); rx_valid = 1'b1; #1;
         chk(sub_valid == sub, "R10/R11 sub_valid", sub_valid, sub);
         if (sub) chk(sub_data == rx_pat(i), "R10 sub_data", sub_data, rx_pat(i));
         chk(!resp_done, "R6/R7 no early done", resp_done, 0);
      end
      @(negedge clk);
      rx_byte = bad_ck ? (ck ^ 8'h01) : ck; rx_valid = 1'b1; #1;
      chk(!sub_valid, "R10 checksum not forwarded", sub_valid, 0);
      @(negedge clk); rx_byte = 8'hA5; #1;
      chk(resp_done, "R12 done after checksum", resp_done, 1);
      chk(err_checksum == (sub && bad_ck), "R9/R10/R11 checksum flag",
          err_checksum, (sub && bad_ck));
      chk(!sub_valid, "R12 idle ignores byte", sub_valid, 0);
      @(negedge clk); rx_valid = 1'b0; #1;
      chk(!resp_done, "R12 single pulse", resp_done, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) pub_mem[i] = 8'((i * 37 + 181) & 255);
      repeat (3) @(negedge clk);
      #1;
      chk(!tx_valid && !sub_valid && !resp_done && !err_id_parity && !err_checksum,
          "R1 reset outputs", {tx_valid, sub_valid, resp_done, err_id_parity, err_checksum}, 0);
      chk(id_out == 8'h00, "R1 reset id_out", id_out, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_pub(8'h3C, 1'b0, 1'b0, 8'd2, 1'b0);   // R2 R6
      do_pub(8'hC5, 1'b1, 1'b1, 8'd0, 1'b0);   // R3 R7 (00 -> 2)
      do_pub(8'h2A, 1'b0, 1'b1, 8'd9, 1'b1);   // R7 (10 -> 4) R8 stalls
      do_pub(8'h37, 1'b0, 1'b1, 8'd0, 1'b0);   // R7 (11 -> 8)
      do_pub(8'h01, 1'b0, 1'b0, 8'd255, 1'b1); // R6 256 bytes R9
      do_pub(8'h10, 1'b1, 1'b0, 8'd0, 1'b0);   // R6 single byte

      do_rx(8'hC3, 1'b0, 1'b0, 8'd5, 2'b01, 1'b0);           // R4 bad parity, R10
      do_rx({ref_par(8'h15), 6'h15}, 1'b0, 1'b1, 8'd0, 2'b01, 1'b1); // R7 (01 -> 2) R10 bad ck
      do_rx(8'hE9, 1'b1, 1'b1, 8'd0, 2'b01, 1'b0);           // R5 R7 (10 -> 4)
      do_rx({ref_par(8'h32), 6'h32}, 1'b0, 1'b1, 8'd0, 2'b10, 1'b1); // R11
      do_rx(8'h77, 1'b1, 1'b0, 8'd20, 2'b11, 1'b1);          // R11 code 11

      // R13: abort a subscribed response midway
      begin
         int d0;
         d0 = done_cnt;
         @(negedge clk);
         cfg_par_off = 1'b1; cfg_len_from_id = 1'b0; cfg_dlc = 8'd7; cfg_action = 2'b01;
         hdr_rx_start = 1'b1;
         @(negedge clk); hdr_rx_start = 1'b0; rx_byte = 8'h05; rx_valid = 1'b1;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_byte = rx_pat(i); rx_valid = 1'b1;
         end
         @(negedge clk); rx_valid = 1'b0;
         do_rx(8'h9C, 1'b1, 1'b0, 8'd3, 2'b01, 1'b0);
         chk(done_cnt == d0 + 1, "R13 abort gives no done", done_cnt - d0, 1);
      end

      do_pub(8'h0F, 1'b0, 1'b0, 8'd4, 1'b0);   // R13 publish after abort
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule